// File: doc/BRIEF.md
# Slot Access Watchdog with Per-Slot Error Status

This block watches every access made to one of five plug-in module slots. An access begins with a one-cycle start strobe that carries the target slot number. From that cycle a counter runs until the module acknowledges. If no acknowledge arrives within a fixed window (243 cycles of a 32 MHz reference, about 7.6 microseconds, set by a parameter), the watchdog ends the access itself. It raises a one-cycle forced-completion pulse toward the host side of the bus.

Each timeout sets a single global bus-error flag. It also sets a sticky error flag owned by the slot that was being accessed. Because the per-slot flag survives later accesses to other slots, a software thread can tell whether its own access failed, even when other threads have touched other slots since then. Software clears the flags by writing ones to them. An interrupt line follows the global flag when software has enabled it.

Top module: `slot_watchdog`

## Requirements
- R1: When an access strobe is not followed by an acknowledge, `force_done` rises exactly TIMEOUT_CYCLES clock edges after the edge that sampled the strobe.
- R2: An acknowledge sampled on any edge from the first up to and including the TIMEOUT_CYCLES-th edge after the strobe completes the access normally: no `force_done` and no error bit set.
- R3: Every timeout sets `master_err`, whichever slot was addressed.
- R4: A timeout sets only the `slot_err` bit whose index equals the binary `acc_slot` value latched with the strobe (0 to 4). A slot value of 5 to 7 sets `master_err` alone.
- R5: A `slot_err` bit stays set through any number of later accesses, completed or timed out, to any slot, until software clears it.
- R6: A write with `clr_we` high clears each status bit whose `clr_mask` bit is one: mask bits 0 to 4 map to `slot_err[0..4]` and bit 5 maps to `master_err`. A clear in the same cycle as a timeout that sets the same bit leaves that bit set.
- R7: `irq` is high exactly when `master_err` is set and the interrupt enable, loaded from `irq_en_wdata` when `irq_en_we` is high, is one.
- R8: `force_done` lasts one cycle. After a timeout the watchdog is idle: a late acknowledge has no effect, and no further pulse occurs until the next strobe.
- R9: A strobe that arrives while an access is being timed restarts the window and relatches the slot. The abandoned access produces no error.
- R10: After reset, `force_done`, `master_err`, all `slot_err` bits, `irq` and `busy` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_start | input | 1 | One-cycle strobe that starts timing an access |
| acc_slot | input | 3 | Target slot number, sampled with the strobe |
| mod_ack | input | 1 | Acknowledge from the addressed module |
| clr_we | input | 1 | Write-one-to-clear strobe for the status bits |
| clr_mask | input | 6 | Bits to clear: 0..4 slot flags, 5 global flag |
| irq_en_we | input | 1 | Load strobe for the interrupt enable |
| irq_en_wdata | input | 1 | New interrupt enable value |
| force_done | output | 1 | One-cycle pulse that forces the access to complete |
| busy | output | 1 | An access is being timed |
| master_err | output | 1 | Global bus-error flag |
| slot_err | output | 5 | Sticky per-slot bus-error flags |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following: the completion pulse lasts one cycle and follows the internal timeout event, a timeout never coincides with an acknowledge, the global flag is set whenever the pulse is, a slot flag only rises with a timeout, slot flags only fall after a clear write, and the interrupt never fires without the global flag. Only the bench scenarios can show that the pulse lands on the exact terminal edge. They also show that an acknowledge on that very edge still counts as a normal completion, that the correct slot bit is chosen, and that out-of-range slots set the global flag alone. The remaining scenario-only behaviours are a clear colliding with a timeout, and a restarted access abandoning the earlier one without error.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // Last count value of the window: reached after limit-1 increments from zero.
  function automatic logic at_terminal(input logic [15:0] count, input logic [15:0] limit);
    return count == (limit - 16'd1);
  endfunction

  // Merge of a set and a clear request for a sticky bit: the set has priority.
  function automatic logic sticky_next(input logic cur, input logic set_req, input logic clr_req);
    return set_req | (cur & ~clr_req);
  endfunction

endpackage

// File: rtl/swd_timer.sv
module swd_timer #(
  parameter int TIMEOUT_CYCLES = 243,
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic running,
  output logic timeout_evt,
  output logic ack_evt
);
  import swd_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      cnt_ext;
  logic             terminal;

  assign cnt_ext     = 16'(cnt_q);
  assign terminal    = at_terminal(cnt_ext, 16'(TIMEOUT_CYCLES));
  assign ack_evt     = running && !start && ack;
  assign timeout_evt = running && !start && !ack && terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt_q   <= '0;
    end else if (running) begin
      if (ack_evt || timeout_evt) begin
        running <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swd_status.sv
module swd_status #(
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 timeout_evt,
  input  logic [SLOT_W-1:0]    slot_sel,
  input  logic                 clr_we,
  input  logic [NUM_SLOTS:0]   clr_mask,
  output logic                 master_err,
  output logic [NUM_SLOTS-1:0] slot_err
);
  import swd_pkg::*;

  logic [NUM_SLOTS-1:0] slot_hit;
  logic [NUM_SLOTS:0]   clr_req;

  assign clr_req = clr_we ? clr_mask : '0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_hit[i] = timeout_evt && (slot_sel == SLOT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_err[i] <= 1'b0;
      else        slot_err[i] <= sticky_next(slot_err[i], slot_hit[i], clr_req[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) master_err <= 1'b0;
    else        master_err <= sticky_next(master_err, timeout_evt, clr_req[NUM_SLOTS]);
  end

endmodule

// File: rtl/slot_watchdog.sv
module slot_watchdog #(
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W = 3,
  parameter int TIMEOUT_CYCLES = 243
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_start,
  input  logic [SLOT_W-1:0]    acc_slot,
  input  logic                 mod_ack,
  input  logic                 clr_we,
  input  logic [NUM_SLOTS:0]   clr_mask,
  input  logic                 irq_en_we,
  input  logic                 irq_en_wdata,
  output logic                 force_done,
  output logic                 busy,
  output logic                 master_err,
  output logic [NUM_SLOTS-1:0] slot_err,
  output logic                 irq
);

  logic              timeout_evt;
  logic              ack_evt;
  logic [SLOT_W-1:0] slot_q;
  logic              irq_en_q;

  swd_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (acc_start),
    .ack        (mod_ack),
    .running    (busy),
    .timeout_evt(timeout_evt),
    .ack_evt    (ack_evt)
  );

  swd_status #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .timeout_evt(timeout_evt),
    .slot_sel   (slot_q),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .master_err (master_err),
    .slot_err   (slot_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= '0;
      force_done <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      if (acc_start) slot_q <= acc_slot;
      force_done <= timeout_evt;
      if (irq_en_we) irq_en_q <= irq_en_wdata;
    end
  end

  assign irq = master_err & irq_en_q;

endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int NUM_SLOTS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mod_ack,
  input logic                 clr_we,
  input logic                 timeout_evt,
  input logic                 ack_evt,
  input logic                 force_done,
  input logic                 master_err,
  input logic [NUM_SLOTS-1:0] slot_err,
  input logic                 irq
);

  p_force_follows_evt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> force_done);

  p_ack_blocks_timeout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> (!mod_ack && !ack_evt));

  p_master_with_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_done |-> master_err);

  p_slot_rise_needs_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_err & ~$past(slot_err)) != '0) |-> force_done);

  p_slot_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_we) |-> (($past(slot_err) & ~slot_err) == '0));

  p_irq_needs_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> master_err);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_done |=> !force_done);

endmodule

bind slot_watchdog swd_checker #(.NUM_SLOTS(NUM_SLOTS)) i_swd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_ack    (mod_ack),
  .clr_we     (clr_we),
  .timeout_evt(timeout_evt),
  .ack_evt    (ack_evt),
  .force_done (force_done),
  .master_err (master_err),
  .slot_err   (slot_err),
  .irq        (irq)
);

// File: tb/test_slot_watchdog.sv
module test_slot_watchdog;
  localparam int NS = 5;
  localparam int SW = 3;
  localparam int T  = 243;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_start = 1'b0;
  logic [SW-1:0] acc_slot = '0;
  logic mod_ack = 1'b0;
  logic clr_we = 1'b0;
  logic [NS:0] clr_mask = '0;
  logic irq_en_we = 1'b0;
  logic irq_en_wdata = 1'b0;
  logic force_done, busy, master_err, irq;
  logic [NS-1:0] slot_err;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [NS-1:0] exp_slot = '0;
  logic exp_master = 1'b0;
  logic exp_en = 1'b0;

  always #10 clk = ~clk;

  slot_watchdog #(.NUM_SLOTS(NS), .SLOT_W(SW), .TIMEOUT_CYCLES(T)) i_slot_watchdog (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_slot(acc_slot),
    .mod_ack(mod_ack), .clr_we(clr_we), .clr_mask(clr_mask),
    .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata),
    .force_done(force_done), .busy(busy), .master_err(master_err),
    .slot_err(slot_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model: a timeout happens when the acknowledge comes later than the window.
  function automatic bit times_out(input int ack_delay);
    return (ack_delay == 0) || (ack_delay > T);
  endfunction

  function automatic logic [NS-1:0] slot_bit(input int s);
    return (s < NS) ? (NS'(1) << s) : '0;
  endfunction

  function automatic logic [NS-1:0] after_clear(input logic [NS-1:0] cur, input logic [NS:0] m);
    return cur & ~m[NS-1:0];
  endfunction

  task automatic check_status(input string req);
    chk({req, " slot_err"}, 32'(slot_err), 32'(exp_slot));
    chk({req, " master_err"}, 32'(master_err), 32'(exp_master));
    chk({req, " irq"}, 32'(irq), 32'(exp_master & exp_en));
  endtask

  task automatic write_clear(input logic [NS:0] m);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    exp_slot = after_clear(exp_slot, m);
    if (m[NS]) exp_master = 1'b0;
  endtask

  task automatic write_en(input logic v);
    irq_en_we = 1'b1; irq_en_wdata = v;
    @(negedge clk);
    irq_en_we = 1'b0;
    exp_en = v;
  endtask

  // One access; ack_delay 0 = never, clr_k>0 drives a full clear on edge k.
  task automatic run_access(input int slot, input int ack_delay, input int clr_k, input int late_ack);
    int pulses = 0;
    int pulse_at = -1;
    bit to;
    logic [NS:0] allm;
    allm = '1;
    to = times_out(ack_delay);
    acc_start = 1'b1; acc_slot = SW'(slot);
    @(negedge clk);
    acc_start = 1'b0;
    for (int k = 1; k <= T + 3; k++) begin
      mod_ack = (k == ack_delay) || (k == late_ack);
      clr_we = (k == clr_k); clr_mask = (k == clr_k) ? allm : '0;
      @(negedge clk);
      if (force_done) begin pulses++; pulse_at = k; end
    end
    mod_ack = 1'b0; clr_we = 1'b0; clr_mask = '0;
    if (clr_k > 0 && clr_k <= T + 3) begin
      exp_slot = '0; exp_master = 1'b0;
    end
    if (to) begin
      exp_slot = exp_slot | slot_bit(slot);
      exp_master = 1'b1;
      chk("R1 pulse edge", 32'(pulse_at), 32'(T));
      chk("R8 pulse count", 32'(pulses), 32'd1);
    end else begin
      chk("R2 no pulse", 32'(pulses), 32'd0);
    end
    chk("R8 idle", 32'(busy), 32'd0);
    check_status("R3/R4/R5");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 force_done", 32'(force_done), 32'd0);
    chk("R10 busy", 32'(busy), 32'd0);
    check_status("R10");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 ack on the terminal edge, and one before it
    run_access(1, T, 0, 0);
    run_access(2, T - 1, 0, 0);
    // R1 ack one edge too late -> timeout on slot 3
    run_access(3, T + 1, 0, 0);
    // R8 late ack after timeout ignored, slot 0
    run_access(0, 0, 0, T + 2);
    // R5 other slots accessed afterwards keep bits
    run_access(4, 5, 0, 0);
    chk("R5 slot3 kept", 32'(slot_err[3]), 32'd1);
    // R7 interrupt enable
    write_en(1'b1);
    check_status("R7 enabled");
    write_en(1'b0);
    check_status("R7 disabled");
    // R6 clear selected slot bit only
    write_clear(7'b0001000 >> 0);
    check_status("R6 partial clear");
    write_clear('1);
    check_status("R6 full clear");
    // R6 clear colliding with a timeout: bit survives
    run_access(2, 0, T, 0);
    chk("R6 collide slot2", 32'(slot_err[2]), 32'd1);
    write_clear('1);
    // R4 out of range slot sets master only
    run_access(6, 0, 0, 0);
    chk("R4 range slots", 32'(slot_err), 32'd0);
    write_clear('1);

    // R9 restart mid-window: slot 1 then slot 4 after 100 edges
    acc_start = 1'b1; acc_slot = 3'd1;
    @(negedge clk);
    acc_start = 1'b0;
    repeat (99) @(negedge clk);
    acc_start = 1'b1; acc_slot = 3'd4;
    @(negedge clk);
    acc_start = 1'b0;
    begin
      int at = -1;
      for (int k = 1; k <= T + 2; k++) begin
        @(negedge clk);
        if (force_done) at = k;
      end
      chk("R9 restart pulse edge", 32'(at), 32'(T));
    end
    exp_slot = slot_bit(4); exp_master = 1'b1;
    check_status("R9 restart slot");
    write_clear('1);

    // Random accesses
    write_en(1'b1);
    for (int n = 0; n < 40; n++) begin
      int s, d;
      s = int'($urandom_range(0, 7));
      d = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, T + 3));
      run_access(s, d, 0, 0);
      if ($urandom_range(0, 4) == 0) begin
        write_clear(7'($urandom_range(0, 127)));
        check_status("R6 random clear");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule